// File: doc/BRIEF.md
# I2C bus clear sequencer

This block frees an I2C bus that a slave has left stuck with SDA held low, usually because the slave stopped in the middle of a byte. The block lets SDA float and toggles SCL a programmed number of times. Each extra clock lets the slave shift out the rest of its byte. The slave then lets go of SDA. The block checks SDA at the end of every SCL high phase. It stops as soon as SDA reads high, or when the programmed count has run out.

Software writes a staging configuration word that carries an enable, a STOP-termination select and the pulse count, which is usually 9. Nothing happens until the shared configuration-load strobe copies the staged word into the active logic. The strobe also latches the bus timing divisor, so the pulses use the same timing as normal transfers. If termination is selected, a STOP condition is placed on the bus after the last pulse. The block then sets a completion flag in the interrupt status word, and software clears it by writing a one back to it. A separate status word tells whether SDA was found free.

Both bus lines are open-drain. An output-enable of 1 pulls the line low, and 0 releases it.

Top module: `i2c_bus_clear`

## Requirements
- R1: After reset, scl_oe_o and sda_oe_o are 0, and int_status_o and bc_status_o read 0.
- R2: The configuration word places the enable in bit 0, STOP termination in bit 1 and the pulse count in bits [23:16]. A load of a word with enable at 0 produces no SCL pulse, no SDA drive and no completion flag.
- R3: Writing the configuration word without a load strobe starts nothing.
- R4: A load strobe that arrives while a sequence runs is ignored. The running sequence keeps its pulse count and completes exactly once.
- R5: During a sequence, each SCL low phase and each SCL high phase lasts div_i+1 clock cycles, where div_i is the value latched by the load. SDA is never driven during the pulses.
- R6: The pulsing ends after the programmed count P, or earlier at the end of the first high phase in which sda_i reads 1. With P = 0, no pulse is made.
- R7: With bit 1 set, three phases follow the last pulse, each one phase long. In the first, SCL and SDA are both pulled low. In the second, SCL is released. In the third, SDA is released while SCL is high, which forms the STOP. With bit 1 clear, SDA is never driven.
- R8: Completion sets bit 11 of int_status_o. An interrupt write with bit 11 set clears it, and a write with bit 11 clear leaves it alone. When completion and a clear fall in the same cycle, the flag ends up set.
- R9: Bit 0 of bc_status_o holds sda_i as sampled in the completion cycle, so 1 means SDA was free and 0 means SDA was still held low. The bit keeps its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the staging configuration word |
| cfg_wdata_i | input | 32 | Configuration word: enable [0], STOP [1], pulse count [23:16] |
| cfg_load_i | input | 1 | Shared configuration-load strobe |
| div_i | input | DIV_W | Phase length minus one, in clock cycles |
| int_we_i | input | 1 | Interrupt status write strobe (write one to clear) |
| int_wdata_i | input | 32 | Interrupt write data; bit 11 clears the completion flag |
| int_status_o | output | 32 | Interrupt status; bit 11 is completion |
| bc_status_o | output | 32 | Outcome; bit 0 is 1 when SDA was free |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |

## Verification
Two things can happen in the same cycle: completion raising the interrupt flag, and a software write that clears it. The bench provokes this by holding a clear write with bit 11 set active for a whole sequence, so the clear is present in the very cycle the sequence completes. The flag must then read 1 at exactly one sample and 0 at the next. A second overlap is also exercised: a fresh load strobe arrives while pulses are running. It is judged by a pulse count that does not change and by a single completion.

// File: rtl/i2c_bc_pkg.sv
package i2c_bc_pkg;
  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_STOP_BIT = 1;
  localparam int CFG_CNT_LSB  = 16;
  localparam int CFG_CNT_MAXW = 8;
  localparam int INT_DONE_BIT = 11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_STP_A,
    ST_STP_B,
    ST_STP_C,
    ST_FIN
  } bc_state_e;
endpackage

// File: rtl/bc_cfg_regs.sv
module bc_cfg_regs
  import i2c_bc_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [31:0]      cfg_wdata_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             busy_i,
  output logic             start_o,
  output logic             stop_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [DIV_W-1:0] div_o
);
  localparam int CNT_HI = CFG_CNT_LSB + CNT_W;

  logic             stg_en_q, stg_stop_q;
  logic [CNT_W-1:0] stg_cnt_q;
  logic             act_stop_q, start_q;
  logic [CNT_W-1:0] act_cnt_q;
  logic [DIV_W-1:0] act_div_q;
  logic             accept;

  // bits of the word that carry no field
  logic unused_cfg_bits;
  if (CNT_HI < 32) begin : g_hi_unused
    assign unused_cfg_bits = ^{cfg_wdata_i[31:CNT_HI], cfg_wdata_i[CFG_CNT_LSB-1:2]};
  end else begin : g_hi_full
    assign unused_cfg_bits = ^cfg_wdata_i[CFG_CNT_LSB-1:2];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_en_q   <= 1'b0;
      stg_stop_q <= 1'b0;
      stg_cnt_q  <= '0;
    end else if (cfg_we_i) begin
      stg_en_q   <= cfg_wdata_i[CFG_EN_BIT];
      stg_stop_q <= cfg_wdata_i[CFG_STOP_BIT];
      stg_cnt_q  <= cfg_wdata_i[CFG_CNT_LSB +: CNT_W];
    end
  end

  // a load is taken only while the sequencer is idle
  assign accept = load_i && !busy_i && !start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_stop_q <= 1'b0;
      act_cnt_q  <= '0;
      act_div_q  <= '0;
      start_q    <= 1'b0;
    end else begin
      start_q <= accept && stg_en_q;
      if (accept) begin
        act_stop_q <= stg_stop_q;
        act_cnt_q  <= stg_cnt_q;
        act_div_q  <= div_i;
      end
    end
  end

  assign start_o = start_q;
  assign stop_o  = act_stop_q;
  assign cnt_o   = act_cnt_q;
  assign div_o   = act_div_q;

  initial begin
    if (CNT_W > CFG_CNT_MAXW || CNT_W < 1) $error("CNT_W out of range");
  end

  AST_LOAD_IGNORED_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && (busy_i || start_q)) |=> ($stable(act_cnt_q) && $stable(act_div_q) && !start_q)); // R4
endmodule

// File: rtl/bc_phase_timer.sv
module bc_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             end_o
);
  logic [DIV_W-1:0] cnt_q;

  assign end_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || end_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  AST_PHASE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= div_i)); // R5
endmodule

// File: rtl/bc_seq_fsm.sv
module bc_seq_fsm
  import i2c_bc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ph_end_i,
  input  logic             sda_i,
  output logic             run_o,
  output logic             busy_o,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             done_o
);
  bc_state_e        state_q, state_d;
  logic [CNT_W-1:0] pulse_q, pulse_d;
  logic [CNT_W:0]   pulse_nxt;
  bc_state_e        tail_st;

  assign pulse_nxt = {1'b0, pulse_q} + (CNT_W+1)'(1);
  assign tail_st   = stop_i ? ST_STP_A : ST_FIN;

  always_comb begin
    state_d = state_q;
    pulse_d = pulse_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        pulse_d = '0;
        state_d = (cnt_i == '0) ? tail_st : ST_LOW;
      end
      ST_LOW:  if (ph_end_i) state_d = ST_HIGH;
      ST_HIGH: if (ph_end_i) begin
        pulse_d = pulse_nxt[CNT_W-1:0];
        // slave released SDA, or count used up
        if (sda_i || pulse_nxt == {1'b0, cnt_i}) state_d = tail_st;
        else                                     state_d = ST_LOW;
      end
      ST_STP_A: if (ph_end_i) state_d = ST_STP_B;
      ST_STP_B: if (ph_end_i) state_d = ST_STP_C;
      ST_STP_C: if (ph_end_i) state_d = ST_FIN;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pulse_q <= '0;
    end else begin
      state_q <= state_d;
      pulse_q <= pulse_d;
    end
  end

  assign run_o    = (state_q != ST_IDLE) && (state_q != ST_FIN);
  assign busy_o   = (state_q != ST_IDLE);
  assign scl_oe_o = (state_q == ST_LOW) || (state_q == ST_STP_A);
  assign sda_oe_o = (state_q == ST_STP_A) || (state_q == ST_STP_B);
  assign done_o   = (state_q == ST_FIN);

  AST_PULSE_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> (pulse_q <= cnt_i)); // R6
  AST_START_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (state_q == ST_IDLE)); // R4
  AST_STOP_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> (!scl_oe_o && stop_i)); // R7
  AST_SINGLE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R4
endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear
  import i2c_bc_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [31:0]      cfg_wdata_i,
  input  logic             cfg_load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             int_we_i,
  input  logic [31:0]      int_wdata_i,
  output logic [31:0]      int_status_o,
  output logic [31:0]      bc_status_o,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o
);
  logic             start, stop, busy, run, ph_end, done;
  logic [CNT_W-1:0] cnt;
  logic [DIV_W-1:0] div_act;
  logic             done_flag_q, sda_free_q, clr_req;

  logic unused_int_bits;
  assign unused_int_bits = ^{int_wdata_i[31:INT_DONE_BIT+1], int_wdata_i[INT_DONE_BIT-1:0]};

  bc_cfg_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_cfg (
    .clk_i, .rst_ni,
    .cfg_we_i, .cfg_wdata_i,
    .load_i  (cfg_load_i),
    .div_i,
    .busy_i  (busy),
    .start_o (start),
    .stop_o  (stop),
    .cnt_o   (cnt),
    .div_o   (div_act)
  );

  bc_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i, .rst_ni,
    .run_i (run),
    .div_i (div_act),
    .end_o (ph_end)
  );

  bc_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i, .rst_ni,
    .start_i  (start),
    .stop_i   (stop),
    .cnt_i    (cnt),
    .ph_end_i (ph_end),
    .sda_i,
    .run_o    (run),
    .busy_o   (busy),
    .scl_oe_o,
    .sda_oe_o,
    .done_o   (done)
  );

  assign clr_req = int_we_i && int_wdata_i[INT_DONE_BIT];

  // set takes priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_flag_q <= 1'b0;
      sda_free_q  <= 1'b0;
    end else begin
      if (done)         done_flag_q <= 1'b1;
      else if (clr_req) done_flag_q <= 1'b0;
      if (done)         sda_free_q  <= sda_i;
    end
  end

  always_comb begin
    int_status_o               = '0;
    int_status_o[INT_DONE_BIT] = done_flag_q;
    bc_status_o                = '0;
    bc_status_o[0]             = sda_free_q;
  end

  AST_DONE_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> int_status_o[INT_DONE_BIT]); // R8
  AST_CLEAR_WORKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done && clr_req) |=> !int_status_o[INT_DONE_BIT]); // R8
  AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |=> $stable(bc_status_o)); // R9
  AST_NO_SDA_WHILE_PULSING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !stop) |-> !sda_oe_o); // R7
endmodule

// File: tb/sim_i2c_bus_clear.sv
module sim_i2c_bus_clear;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_load = 1'b0, int_we = 1'b0;
  logic [31:0] cfg_wdata = '0, int_wdata = '0;
  logic [7:0]  div = '0;
  logic [31:0] int_status, bc_status;
  logic        scl_oe, sda_oe, sda_in, slave_hold;

  int tests = 0, fails = 0;
  int rise_cnt = 0, rise_base = 0, k_rel = 0;
  bit mon = 1'b0;
  int pulses, bad_w, sda_drv, stops, run_len, n_low;
  logic prev_scl, prev_sda;
  int cur_div = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_bus_clear u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_load_i(cfg_load),
    .div_i(div), .int_we_i(int_we), .int_wdata_i(int_wdata),
    .int_status_o(int_status), .bc_status_o(bc_status),
    .sda_i(sda_in), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  // slave model: holds SDA until k_rel SCL rises seen with SDA not driven by the block
  assign slave_hold = (rise_cnt - rise_base) < k_rel;
  assign sda_in = ~(sda_oe | slave_hold);
  always @(negedge scl_oe) if (rst_n && !sda_oe) rise_cnt = rise_cnt + 1;

  always @(negedge clk) begin
    if (!mon) begin
      pulses = 0; bad_w = 0; sda_drv = 0; stops = 0; run_len = 1; n_low = 0;
      prev_scl = scl_oe; prev_sda = sda_oe;
    end else begin
      if (scl_oe != prev_scl) begin
        if (!sda_oe) begin
          if (prev_scl && run_len != cur_div + 1) bad_w++;
          if (!prev_scl && n_low > 0 && run_len != cur_div + 1) bad_w++;
        end
        if (scl_oe && !sda_oe) begin pulses++; n_low++; end
        run_len = 1;
      end else run_len++;
      if (sda_oe && !prev_sda) sda_drv++;
      if (!sda_oe && prev_sda && !scl_oe) stops++;
      prev_scl = scl_oe; prev_sda = sda_oe;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  function automatic int exp_pulses(int p, int k);
    if (p == 0) return 0;
    if (k < 1) return 1;
    return (k < p) ? k : p;
  endfunction

  function automatic logic [31:0] cfg_word(int p, bit term, bit en);
    return (32'(p & 8'hff) << 16) | (32'(term) << 1) | 32'(en);
  endfunction

  task automatic run_case(int p, bit term, int d, int k, bit reload, bit hold_clr);
    int lim;
    bit seen;
    rise_base = rise_cnt; k_rel = k;
    @(negedge clk);
    cfg_we = 1; cfg_wdata = cfg_word(p, term, 1'b1); div = 8'(d); cur_div = d; mon = 1;
    @(negedge clk);
    cfg_we = 0; cfg_load = 1;
    if (hold_clr) begin int_we = 1; int_wdata = 32'h800; end
    @(negedge clk);
    cfg_load = 0;
    if (reload) begin
      repeat (3) @(negedge clk);
      cfg_we = 1; cfg_wdata = cfg_word(p + 5, term, 1'b1); div = 8'(d + 1);
      @(negedge clk);
      cfg_we = 0; cfg_load = 1;
      @(negedge clk);
      cfg_load = 0;
    end
    lim = (p + 5) * 2 * (d + 1) + 20;
    seen = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (int_status[11]) begin seen = 1; break; end
    end
    check(reload ? "R4" : "R8", "done flag set", int'(seen), 1);
    check(reload ? "R4" : "R6", "pulse count", pulses, exp_pulses(p, k));
    check("R5", "phase width errors", bad_w, 0);
    check("R7", "SDA drive events", sda_drv, term ? 1 : 0);
    check("R7", "STOP edges", stops, term ? 1 : 0);
    check("R9", "SDA free status", int'(bc_status[0]), (k <= p) ? 1 : 0);
    mon = 0;
    if (hold_clr) begin
      @(negedge clk);
      check("R8", "flag after set/clear collision then clear", int'(int_status[11]), 0);
      int_we = 0; int_wdata = 0;
    end else begin
      int_we = 1; int_wdata = 32'hFFFF_F7FF;
      @(negedge clk);
      int_we = 0;
      check("R8", "flag kept on write with bit 11 clear", int'(int_status[11]), 1);
      int_we = 1; int_wdata = 32'h0000_0800;
      @(negedge clk);
      int_we = 0; int_wdata = 0;
      check("R8", "flag cleared by write one", int'(int_status[11]), 0);
    end
    if (reload) begin
      repeat (2 * (p + 10) * (d + 3)) @(negedge clk);
      check("R4", "no second completion", int'(int_status[11]), 0);
    end
  endtask

  task automatic idle_case(bit en, bit do_load);
    @(negedge clk);
    cfg_we = 1; cfg_wdata = cfg_word(6, 1'b1, en); div = 8'd1; mon = 1;
    @(negedge clk);
    cfg_we = 0; cfg_load = do_load;
    @(negedge clk);
    cfg_load = 0;
    repeat (60) @(negedge clk);
    check(do_load ? "R2" : "R3", "SCL pulses without start", pulses, 0);
    check(do_load ? "R2" : "R3", "SDA drive without start", sda_drv, 0);
    check(do_load ? "R2" : "R3", "done flag without start", int'(int_status[11]), 0);
    mon = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL R8 watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    int p, k, d;
    bit t;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", "scl_oe after reset", int'(scl_oe), 0);
    check("R1", "sda_oe after reset", int'(sda_oe), 0);
    check("R1", "int status after reset", int'(int_status), 0);
    check("R1", "bc status after reset", int'(bc_status), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    idle_case(1'b0, 1'b1);           // R2 enable clear
    idle_case(1'b1, 1'b0);           // R3 no load strobe

    run_case(9, 1'b1, 2, 20, 1'b0, 1'b0);  // held throughout, STOP
    run_case(9, 1'b0, 1, 3,  1'b0, 1'b0);  // early release
    run_case(0, 1'b1, 0, 0,  1'b0, 1'b0);  // zero count with STOP
    run_case(5, 1'b0, 0, 0,  1'b0, 1'b0);  // bus free at start
    run_case(4, 1'b0, 3, 30, 1'b1, 1'b0);  // R4 load while running
    run_case(3, 1'b1, 1, 10, 1'b0, 1'b1);  // R8 set/clear collision
    run_case(1, 1'b0, 0, 12, 1'b0, 1'b1);  // R8 collision, single pulse

    for (int n = 0; n < 14; n++) begin
      p = int'($urandom_range(0, 10));
      k = int'($urandom_range(0, 12));
      d = int'($urandom_range(0, 3));
      t = 1'($urandom_range(0, 1));
      run_case(p, t, d, k, 1'b0, 1'b0);
    end
    summary();
  end
endmodule